// File: doc/BRIEF.md
# UART Receiver with Multiprocessor Wake-up Filtering

This block is one asynchronous serial receive channel. It turns a serial line into bytes using a 16x oversampling tick that the surrounding chip supplies. A small register port configures the frame shape, returns the received byte and the status, and clears errors. Four registered status outputs give the same flags directly to nearby logic.

Several nodes can share one serial line. For that case the receiver can run a multiprocessor frame format, in which one marker bit follows the data bits and tags each byte as an address or as data. When wake-up filtering is also enabled, a byte whose marker bit is 0 is dropped. It touches neither the data register nor any flag. A node then only responds to marked traffic until software decides to listen to data bytes again.

The register port uses a 2-bit address. Address 0 is the channel control register. Address 1 is the format register, where bit 0 selects the multiprocessor format. Address 2 is the received data register. Address 3 is a read-only status view. A read returns its value on `reg_rdata` one clock after `reg_rd` is sampled.

Top module: `mpuart_rx`

## Requirements
- R1: After a synchronous reset, all four status outputs are 0, and reads of addresses 0, 1 and 2 return 0.
- R2: Control bits 2:0 set the frame. Bit 2 = 1 gives eight data bits; with bit 2 = 0 there are seven data bits and the stored bit 7 is 0. Bit 1 = 1 adds a parity slot after the data. Bit 0 = 1 gives two stop bits. Data arrives LSB first, each bit lasts 16 ticks, and the start bit is confirmed low on the 8th tick after the falling edge is seen.
- R3: With the parity slot present and the multiprocessor format off, a parity bit that breaks even parity over the data bits sets `err_parity`.
- R4: A low first stop bit sets `err_framing`. The byte is still stored and flagged ready.
- R5: An accepted frame sets `rx_ready`. A read of address 2 returns the stored byte and clears `rx_ready`.
- R6: With format bit 0 = 1, the bit after the data is the marker bit and parity is never checked. Control bit 3, when read, returns the marker bit of the last accepted frame.
- R7: With the multiprocessor format on and control bit 7 (wake-up) = 1, a frame whose marker bit is 0 leaves the data register, the last marker bit and all flags unchanged. A frame whose marker bit is 1 is accepted.
- R8: With the multiprocessor format off, control bit 7 has no effect and every frame is accepted.
- R9: A frame that completes while `rx_ready` is set, and is not being read in that cycle, keeps the older byte and sets `err_overrun`.
- R10: A write to address 0 with bit 3 = 0 clears the overrun, framing and parity flags. With bit 3 = 1 they are left as they are. Bits 7, 6, 5, 4 and 2:0 are stored and read back in place.
- R11: With control bit 6 (receiver enable) = 0, no frame is received. Clearing it in the middle of a frame abandons that frame and leaves the stored byte and all flags as they were.
- R12: If a read of address 2 falls in the same cycle as a frame completing, the read returns the older byte, the new byte is stored, `rx_ready` stays set and `err_overrun` stays clear.
- R13: A read of address 3 returns {4'b0, parity, framing, overrun, ready} and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| reg_addr | input | 2 | Register select: 0 control, 1 format, 2 data, 3 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| rx_ready | output | 1 | A received byte is waiting |
| err_overrun | output | 1 | A byte arrived while the previous one was unread |
| err_framing | output | 1 | A first stop bit was sampled low |
| err_parity | output | 1 | A parity mismatch was seen |

## Verification
Two things can land on the same clock edge: the completion of a frame and a software read of the data register. The bench first times a reference frame from its start bit to the rise of `rx_ready`, with the tick phase fixed. It then replays an identical frame while an older byte is still waiting, and places the data read exactly on the completion edge. The result is judged by three things: the read must return the older byte, the overrun flag must stay clear, and a later read must return the new byte. Wake-up filtering is judged the same way at the ports. Dropped frames carry a bad stop bit and a zero marker bit, and the flags, the data register and the marker-bit readback are checked afterwards.

// File: rtl/mpu_rx_pkg.sv
`timescale 1ns/1ps
package mpu_rx_pkg;
  localparam int BYTE_W = 8;

  // register map
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_FMT  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  // control register bit positions
  localparam int CB_WAKE  = 7;
  localparam int CB_RXEN  = 6;
  localparam int CB_TXEN  = 5;
  localparam int CB_SPARE = 4;
  localparam int CB_MARK  = 3;
  localparam int CB_LEN8  = 2;
  localparam int CB_PAR   = 1;
  localparam int CB_STOP2 = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_EXTRA, ST_STOP, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              mark;
    logic              ferr;
    logic              perr;
  } rx_frame_t;
endpackage

// File: rtl/mpu_rx_sync.sv
`timescale 1ns/1ps
module mpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_deser.sv
`timescale 1ns/1ps
module mpu_rx_deser
  import mpu_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rxd,
  input  logic      en,
  input  logic      len8,
  input  logic      par_en,
  input  logic      mp_fmt,
  input  logic      stop2,
  output logic      done,
  output rx_frame_t frame
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [BYTE_W-1:0] sh;
  logic              xbit;

  logic [BW-1:0]     last_bit;
  logic              at_end;
  logic              extra_en;
  logic [BYTE_W-1:0] word;

  assign last_bit = len8 ? BW'(BYTE_W-1) : BW'(BYTE_W-2);
  assign at_end   = tick && (cnt == LAST);
  assign extra_en = par_en | mp_fmt;
  assign word     = len8 ? sh : {1'b0, sh[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
      xbit  <= 1'b0;
      done  <= 1'b0;
      frame <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (tick && !rxd) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (tick) begin
              if (cnt == MID) begin
                cnt  <= '0;
                bidx <= '0;
                st   <= rxd ? ST_IDLE : ST_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (at_end) begin
              cnt  <= '0;
              sh   <= {rxd, sh[BYTE_W-1:1]};
              bidx <= bidx + 1'b1;
              if (bidx == last_bit) st <= extra_en ? ST_EXTRA : ST_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_EXTRA: begin
            if (at_end) begin
              cnt  <= '0;
              xbit <= rxd;
              st   <= ST_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_end) begin
              cnt        <= '0;
              done       <= 1'b1;
              frame.data <= word;
              frame.mark <= mp_fmt & xbit;
              frame.ferr <= ~rxd;
              frame.perr <= par_en & ~mp_fmt & (xbit ^ (^word));
              st         <= stop2 ? ST_STOP2 : ST_IDLE;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP2: begin
            if (at_end) begin
              cnt <= '0;
              st  <= ST_IDLE;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: a cleared enable parks the receiver in idle with no completion
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st == ST_IDLE && !done))
    else $error("receiver not idle after enable cleared");

  // R2: a completion only follows a tick seen in the stop-bit state
  assert_done_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(tick) && $past(st) == ST_STOP))
    else $error("frame completion outside stop-bit sampling");
endmodule

// File: rtl/mpu_rx_regfile.sv
`timescale 1ns/1ps
module mpu_rx_regfile
  import mpu_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              done,
  input  rx_frame_t         frame,
  output logic              en,
  output logic              len8,
  output logic              par_en,
  output logic              stop2,
  output logic              mp_fmt,
  output logic              rx_ready,
  output logic              err_overrun,
  output logic              err_framing,
  output logic              err_parity
);
  logic              wake_q, rxen_q, txen_q, spare_q, fmt_q;
  logic [2:0]        mode_q;
  logic [BYTE_W-1:0] data_q;
  logic              mark_q, ready_q, ovr_q, fe_q, pe_q;

  logic wr_ctrl, consume, clr_err, drop, take, room;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign consume = reg_rd && (reg_addr == A_DATA);
  assign clr_err = wr_ctrl && !reg_wdata[CB_MARK];
  assign drop    = fmt_q && wake_q && !frame.mark;
  assign take    = done && !drop;
  assign room    = !ready_q || consume;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q    <= 1'b0;
      rxen_q    <= 1'b0;
      txen_q    <= 1'b0;
      spare_q   <= 1'b0;
      mode_q    <= '0;
      fmt_q     <= 1'b0;
      data_q    <= '0;
      mark_q    <= 1'b0;
      ready_q   <= 1'b0;
      ovr_q     <= 1'b0;
      fe_q      <= 1'b0;
      pe_q      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        wake_q  <= reg_wdata[CB_WAKE];
        rxen_q  <= reg_wdata[CB_RXEN];
        txen_q  <= reg_wdata[CB_TXEN];
        spare_q <= reg_wdata[CB_SPARE];
        mode_q  <= reg_wdata[2:0];
      end
      if (reg_wr && reg_addr == A_FMT) fmt_q <= reg_wdata[0];

      if (clr_err) begin
        ovr_q <= 1'b0;
        fe_q  <= 1'b0;
        pe_q  <= 1'b0;
      end
      if (consume) ready_q <= 1'b0;

      if (take) begin
        if (room) begin
          data_q  <= frame.data;
          mark_q  <= frame.mark;
          ready_q <= 1'b1;
          if (frame.ferr) fe_q <= 1'b1;
          if (frame.perr) pe_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end

      if (reg_rd) begin
        unique case (reg_addr)
          A_CTRL:  reg_rdata <= {wake_q, rxen_q, txen_q, spare_q, mark_q, mode_q};
          A_FMT:   reg_rdata <= {{(BYTE_W-1){1'b0}}, fmt_q};
          A_DATA:  reg_rdata <= data_q;
          default: reg_rdata <= {4'b0, pe_q, fe_q, ovr_q, ready_q};
        endcase
      end
    end
  end

  assign en          = rxen_q;
  assign len8        = mode_q[CB_LEN8];
  assign par_en      = mode_q[CB_PAR];
  assign stop2       = mode_q[CB_STOP2];
  assign mp_fmt      = fmt_q;
  assign rx_ready    = ready_q;
  assign err_overrun = ovr_q;
  assign err_framing = fe_q;
  assign err_parity  = pe_q;

  // R5: an accepted frame leaves a byte waiting
  assert_ready_set_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !drop) |=> ready_q)
    else $error("accepted frame did not raise ready");

  // R7: a filtered frame leaves data and marker readback untouched
  assert_discard_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (done && drop) |=> ($stable(data_q) && $stable(mark_q)))
    else $error("filtered frame changed stored state");

  // R9: a frame landing on an unread byte keeps the old byte and flags overrun
  assert_overrun_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !drop && ready_q && !consume) |=> (ovr_q && $stable(data_q)))
    else $error("overrun handling wrong");

  // R10: a clearing write with no concurrent acceptance empties the error flags
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !take) |=> !(ovr_q || fe_q || pe_q))
    else $error("error flags survived clear");

  // R12: a read on the completion edge makes room without overrun
  assert_read_race_R12: assert property (@(posedge clk) disable iff (rst)
    (take && ready_q && consume && !clr_err) |=> (ready_q && $stable(ovr_q)))
    else $error("coincident read and completion mishandled");
endmodule

// File: rtl/mpuart_rx.sv
`timescale 1ns/1ps
module mpuart_rx
  import mpu_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_in,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rx_ready,
  output logic       err_overrun,
  output logic       err_framing,
  output logic       err_parity
);
  logic      rxd;
  logic      en, len8, par_en, stop2, mp_fmt;
  logic      done;
  rx_frame_t frame;

  mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .dout (rxd)
  );

  mpu_rx_deser #(.OVS(OVS)) u_deser (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .rxd    (rxd),
    .en     (en),
    .len8   (len8),
    .par_en (par_en),
    .mp_fmt (mp_fmt),
    .stop2  (stop2),
    .done   (done),
    .frame  (frame)
  );

  mpu_rx_regfile u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .done        (done),
    .frame       (frame),
    .en          (en),
    .len8        (len8),
    .par_en      (par_en),
    .stop2       (stop2),
    .mp_fmt      (mp_fmt),
    .rx_ready    (rx_ready),
    .err_overrun (err_overrun),
    .err_framing (err_framing),
    .err_parity  (err_parity)
  );
endmodule

// File: tb/mpuart_rx_bench.sv
`timescale 1ns/1ps
module mpuart_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       rx_ready, err_overrun, err_framing, err_parity;

  always #2.5 clk = ~clk;

  mpuart_rx u_mpuart_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_ready(rx_ready), .err_overrun(err_overrun),
    .err_framing(err_framing), .err_parity(err_parity)
  );

  localparam int BITCLK = 64;   // 16 ticks of 4 clocks each

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    settled = 0;
  bit    finished = 0;
  int    tcnt = 0;
  int    cyc = 0;
  int    t_launch = 0, t_rise = 0;
  bit    launched = 0;
  bit    rdy_prev = 0;

  // behavioural model state
  bit       m_wake, m_rxen, m_txen, m_spare, m_fmt;
  bit [2:0] m_mode;
  bit [7:0] e_data;
  bit       e_ready, e_ovr, e_fe, e_pe, e_mark;

  initial forever begin
    @(posedge clk);
    #1;
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rx_ready && !rdy_prev) t_rise = cyc;
    rdy_prev = rx_ready;
    if (settled && !rst)
      chk(cur_req, {4'b0, err_parity, err_framing, err_overrun, rx_ready},
                   {4'b0, e_pe, e_fe, e_ovr, e_ready});
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    settled = 0;
    reg_write(2'd0, v);
    m_wake = v[7]; m_rxen = v[6]; m_txen = v[5]; m_spare = v[4]; m_mode = v[2:0];
    if (!v[3]) begin e_ovr = 0; e_fe = 0; e_pe = 0; end
    @(negedge clk);
    settled = 1;
  endtask

  task automatic write_fmt(input bit b);
    reg_write(2'd1, {7'b0, b});
    m_fmt = b;
  endtask

  task automatic read_data(input string req);
    logic [7:0] v;
    settled = 0;
    reg_read(2'd2, v);
    chk(req, v, e_data);
    e_ready = 0;
    @(negedge clk);
    settled = 1;
  endtask

  task automatic read_ctrl(input string req);
    logic [7:0] v;
    reg_read(2'd0, v);
    chk(req, v, {m_wake, m_rxen, m_txen, m_spare, e_mark, m_mode});
  endtask

  task automatic read_stat(input string req);
    logic [7:0] v;
    reg_read(2'd3, v);
    chk(req, v, {4'b0, e_pe, e_fe, e_ovr, e_ready});
  endtask

  function automatic void model_frame(input bit [7:0] b, input bit x, input bit stopv);
    bit [7:0] d;
    bit mk;
    if (!m_rxen) return;
    d  = m_mode[2] ? b : {1'b0, b[6:0]};
    mk = m_fmt ? x : 1'b0;
    if (m_fmt && m_wake && !mk) return;
    if (e_ready) e_ovr = 1;
    else begin
      e_data = d; e_ready = 1; e_mark = mk;
      if (!stopv) e_fe = 1;
      if (m_mode[1] && !m_fmt && (x != ^d)) e_pe = 1;
    end
  endfunction

  task automatic send_frame(input bit [7:0] b, input bit x, input bit stopv);
    int  nb;
    bit  ext, two;
    settled = 0;
    nb  = m_mode[2] ? 8 : 7;
    ext = m_mode[1] || m_fmt;
    two = m_mode[0];
    @(negedge clk);
    while (tcnt != 1) @(negedge clk);
    t_launch = cyc; launched = 1;
    rx_in = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_in = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (ext) begin
      rx_in = x;
      repeat (BITCLK) @(negedge clk);
    end
    rx_in = stopv;
    repeat (BITCLK) @(negedge clk);
    if (two) begin
      rx_in = 1'b1;
      repeat (BITCLK) @(negedge clk);
    end
    rx_in = 1'b1;
    repeat (96) @(negedge clk);
    launched = 0;
    model_frame(b, x, stopv);
    settled = 1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    int lat;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    settled = 1;

    // R1: reset state
    cur_req = "R1";
    read_ctrl("R1");
    reg_read(2'd1, v); chk("R1", v, 8'h00);
    read_stat("R1");
    read_data("R1");

    // R10: field storage and readback, bit 4 included
    cur_req = "R10";
    write_ctrl(8'hB7);
    read_ctrl("R10");

    // R2/R5: plain 8N1 byte
    cur_req = "R5";
    write_ctrl(8'h4C);
    read_ctrl("R10");
    send_frame(8'hA5, 1'b0, 1'b1);
    read_data("R2");
    send_frame(8'h3C, 1'b0, 1'b1);
    read_data("R5");

    // R2: seven data bits
    cur_req = "R2";
    write_ctrl(8'h48);
    send_frame(8'hD3, 1'b0, 1'b1);
    read_data("R2");

    // R3: parity
    cur_req = "R3";
    write_ctrl(8'h4E);
    send_frame(8'h37, 1'b1, 1'b1);
    read_data("R3");
    send_frame(8'h37, 1'b0, 1'b1);
    read_stat("R13");
    cur_req = "R10";
    write_ctrl(8'h4E);
    read_data("R3");
    write_ctrl(8'h46);
    read_stat("R10");

    // R2/R4: two stop bits, framing on first stop only
    cur_req = "R4";
    write_ctrl(8'h4D);
    send_frame(8'hC3, 1'b0, 1'b1);
    read_data("R2");
    send_frame(8'h0F, 1'b0, 1'b0);
    read_stat("R4");
    read_data("R4");
    write_ctrl(8'h45);
    write_ctrl(8'h4F);
    send_frame(8'h0F, 1'b0, 1'b1);
    read_data("R2");

    // R9: overrun
    cur_req = "R9";
    write_ctrl(8'h4C);
    send_frame(8'h10, 1'b0, 1'b1);
    send_frame(8'h20, 1'b0, 1'b1);
    read_stat("R13");
    read_data("R9");
    write_ctrl(8'h44);

    // R12: read on the completion edge
    cur_req = "R12";
    write_ctrl(8'h4C);
    send_frame(8'h61, 1'b0, 1'b1);
    lat = t_rise - t_launch;
    read_data("R12");
    send_frame(8'h62, 1'b0, 1'b1);
    fork
      send_frame(8'h63, 1'b0, 1'b1);
      begin
        wait (launched);
        while (cyc != t_launch + lat - 1) @(negedge clk);
        reg_addr = 2'd2; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R12", reg_rdata, 8'h62);
        e_ready = 0;
      end
    join
    read_stat("R12");
    read_data("R12");

    // R6: multiprocessor format, no parity check, marker readback
    cur_req = "R6";
    write_fmt(1'b1);
    write_ctrl(8'h4E);
    send_frame(8'h81, 1'b1, 1'b1);
    read_ctrl("R6");
    read_data("R6");
    send_frame(8'h7E, 1'b0, 1'b1);
    read_ctrl("R6");
    read_data("R6");
    write_ctrl(8'h4C);
    send_frame(8'h44, 1'b1, 1'b1);
    read_data("R6");

    // R7: wake-up filtering
    cur_req = "R7";
    write_ctrl(8'hCC);
    send_frame(8'h11, 1'b0, 1'b1);
    read_ctrl("R7");
    read_stat("R7");
    send_frame(8'h22, 1'b0, 1'b0);
    read_stat("R7");
    read_data("R7");
    send_frame(8'h33, 1'b1, 1'b1);
    read_ctrl("R7");
    read_data("R7");

    // R8: wake-up ignored without multiprocessor format
    cur_req = "R8";
    write_fmt(1'b0);
    write_ctrl(8'hCC);
    send_frame(8'h5A, 1'b0, 1'b1);
    read_data("R8");
    read_ctrl("R8");

    // R11: receiver disabled and mid-frame abort
    cur_req = "R11";
    write_ctrl(8'h4C);
    fork
      send_frame(8'h99, 1'b0, 1'b1);
      begin
        repeat (300) @(negedge clk);
        write_ctrl(8'h0C);
      end
    join
    read_stat("R11");
    send_frame(8'h77, 1'b0, 1'b1);
    read_stat("R11");
    read_data("R11");
    write_ctrl(8'h4C);
    send_frame(8'h55, 1'b0, 1'b1);
    read_data("R11");

    repeat (10) @(negedge clk);
    summary();
  end
endmodule